// File: doc/BRIEF.md
# OTP Parallel Fuse Reader

This block gives software access to a small one-time-programmable fuse array through three memory-mapped registers: a control register, a data port and a pointer register. Software first places the array in parallel mode and releases its power-on reset. It then pulses a read strobe high, low for a minimum time, and high again. The strobe copies the whole array into an internal word buffer. After that, each read of the data port returns the buffered 32-bit word that the pointer selects. The pointer can advance on its own after every data read, so a loop of port reads walks the array from word 0 upward.

The fuse content is a parameterised constant held inside the block, so no external model is needed. The array width is set in bits. The number of 32-bit words is derived from it, and any bits past the real width read as zero in the last word. The minimum low time of the strobe is a parameter counted in clock cycles. A low pulse that is too short does not load the buffer and raises a sticky error flag.

Top module: `otp_par_rd_ctrl`

## Requirements
- R1: After reset, reads of the control register, the pointer register and the data port all return 0, and `bus_rdata` is 0.
- R2: The control register (byte address 0x0) reads back the written values of bit 15 (mode, 1 = serial, 0 = parallel), bit 14 (pointer reset), bit 13 (power-on reset release, active low in the array, so 1 = running) and bit 3 (strobe). Bit 31 reads as the sticky strobe error flag. All other bits read as 0.
- R3: The pointer register (byte address 0x8) reads back bit 8 (auto-increment enable) and the pointer value in its low bits, with the remaining bits 0.
- R4: The data port (byte address 0x4) returns 0 unless all three hold: bit 13 is set, bit 15 is clear, and a strobe sequence has completed since bit 13 was last set.
- R5: A strobe sequence is: bit 3 seen at 1, then bit 3 held at 0 for at least MIN_LOW clock cycles, then bit 3 at 1. It loads every fuse word into the buffer.
- R6: A strobe low phase shorter than MIN_LOW cycles loads nothing and sets control bit 31. Bit 31 stays set until reset, and writes to it are ignored.
- R7: With bit 8 set, every data-port read advances the pointer by one, wrapping from the last word to word 0. With bit 8 clear, the pointer holds.
- R8: While control bit 14 is 1, the pointer is held at 0.
- R9: Fuse word i equals FUSE_SEED XOR (i × 0x01010101). Bits at or beyond NUM_BITS read as 0 in the last word.
- R10: Clearing bit 13 discards the buffered data. After bit 13 is set again, the port reads 0 until a new strobe sequence completes.
- R11: While bit 15 is set, the data port reads 0 and strobe activity loads nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| bus_cs | input | 1 | Access select, one access per cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, registered, valid the cycle after the read |

## Verification
The bench builds the block with NUM_BITS = 97 and MIN_LOW = 4. This gives four words, the last of which has only one live bit, so the tail masking and the wrap of a 2-bit pointer both come into play. The short MIN_LOW lets the bench place strobe low phases exactly at the threshold and one cycle under it within a few cycles. It can then show the latch boundary, the error flag, and the discard caused by power-on reset and serial mode.

// File: rtl/otp_ctrl_pkg.sv
package otp_ctrl_pkg;

  // register byte addresses (software-visible layout)
  localparam logic [3:0] ADR_CTRL = 4'h0;
  localparam logic [3:0] ADR_DATA = 4'h4;
  localparam logic [3:0] ADR_PTR  = 4'h8;

  // control register bit positions
  localparam int CB_MODE = 15;
  localparam int CB_PRST = 14;
  localparam int CB_POR  = 13;
  localparam int CB_STB  = 3;
  localparam int CB_ERR  = 31;

  // pointer register bit positions
  localparam int PB_INC = 8;

  typedef enum logic [1:0] {
    STB_WAIT_HI = 2'd0,
    STB_HIGH    = 2'd1,
    STB_LOW     = 2'd2
  } stb_state_e;

endpackage

// File: rtl/otp_fuse_rom.sv
module otp_fuse_rom #(
  parameter int          NUM_BITS  = 69,
  parameter int          WORDS     = 3,
  parameter logic [31:0] FUSE_SEED = 32'h5A3C_96E1
) (
  output logic [WORDS-1:0][31:0] rom_words
);

  for (genvar w = 0; w < WORDS; w++) begin : g_word
    localparam int          LIVE  = (NUM_BITS - 32*w >= 32) ? 32 : (NUM_BITS - 32*w);
    localparam logic [31:0] MASK  = (LIVE >= 32) ? 32'hFFFF_FFFF
                                                 : ((32'h1 << LIVE) - 32'h1);
    localparam logic [31:0] PATT  = FUSE_SEED ^ (32'(w) * 32'h0101_0101);
    assign rom_words[w] = PATT & MASK;
  end

endmodule

// File: rtl/otp_strobe_seq.sv
module otp_strobe_seq
  import otp_ctrl_pkg::*;
#(
  parameter int MIN_LOW = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic enable,
  input  logic stb,
  output logic latch_p,
  output logic err_p
);

  localparam int CNT_W = $clog2(MIN_LOW + 1);
  localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(MIN_LOW);

  stb_state_e       state_q, state_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    cnt_en  = 1'b0;
    latch_p = 1'b0;
    err_p   = 1'b0;
    if (!enable) begin
      state_d = STB_WAIT_HI;
      cnt_d   = '0;
      cnt_en  = 1'b1;
    end else begin
      unique case (state_q)
        STB_WAIT_HI: if (stb) state_d = STB_HIGH;
        STB_HIGH: begin
          if (!stb) begin
            state_d = STB_LOW;
            cnt_d   = CNT_W'(1);
            cnt_en  = 1'b1;
          end
        end
        STB_LOW: begin
          if (stb) begin
            state_d = STB_HIGH;
            if (cnt_q >= CNT_MAX) latch_p = 1'b1;
            else                  err_p   = 1'b1;
          end else if (cnt_q < CNT_MAX) begin
            cnt_d  = cnt_q + CNT_W'(1);
            cnt_en = 1'b1;
          end
        end
        default: state_d = STB_WAIT_HI;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= STB_WAIT_HI;
    end else begin
      state_q <= state_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

endmodule

// File: rtl/otp_word_buf.sv
module otp_word_buf #(
  parameter int WORDS = 3,
  parameter int PTR_W = 2
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [WORDS-1:0][31:0] rom_words,
  input  logic                   latch_p,
  input  logic                   discard,
  input  logic                   ptr_rst,
  input  logic                   ptr_wr,
  input  logic [PTR_W-1:0]       ptr_wdata,
  input  logic                   advance,
  output logic [PTR_W-1:0]       ptr,
  output logic                   valid,
  output logic [31:0]            rd_word
);

  localparam logic [PTR_W-1:0] LAST = PTR_W'(WORDS - 1);

  logic [WORDS-1:0][31:0] word_q;
  logic [PTR_W-1:0]       ptr_q, ptr_d;
  logic                   ptr_en;
  logic                   valid_q, valid_d, valid_en;

  // pointer next state: reset bit > register write > auto-advance
  always_comb begin
    ptr_d  = ptr_q;
    ptr_en = 1'b0;
    if (ptr_rst) begin
      ptr_d  = '0;
      ptr_en = 1'b1;
    end else if (ptr_wr) begin
      ptr_d  = ptr_wdata;
      ptr_en = 1'b1;
    end else if (advance) begin
      ptr_d  = (ptr_q >= LAST) ? '0 : ptr_q + PTR_W'(1);
      ptr_en = 1'b1;
    end
  end

  always_comb begin
    valid_d  = valid_q;
    valid_en = 1'b0;
    if (discard) begin
      valid_d  = 1'b0;
      valid_en = 1'b1;
    end else if (latch_p) begin
      valid_d  = 1'b1;
      valid_en = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr_q <= '0;
    end else if (ptr_en) begin
      ptr_q <= ptr_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
    end else if (valid_en) begin
      valid_q <= valid_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word_q <= '0;
    end else if (latch_p && !discard) begin
      word_q <= rom_words;
    end
  end

  always_comb begin
    rd_word = '0;
    if (valid_q && (int'(ptr_q) < WORDS)) rd_word = word_q[ptr_q];
  end

  assign ptr   = ptr_q;
  assign valid = valid_q;

endmodule

// File: rtl/otp_par_rd_ctrl.sv
module otp_par_rd_ctrl
  import otp_ctrl_pkg::*;
#(
  parameter int          NUM_BITS  = 69,
  parameter int          MIN_LOW   = 8,
  parameter logic [31:0] FUSE_SEED = 32'h5A3C_96E1,
  parameter int          ADDR_W    = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_cs,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata
);

  localparam int WORDS = (NUM_BITS + 31) / 32;
  localparam int PTR_W = (WORDS > 1) ? $clog2(WORDS) : 1;

  // control register fields
  logic mode_q, prst_q, por_q, stb_q, err_q;
  logic mode_d, prst_d, por_d, stb_d, err_d;
  logic ctrl_en, err_en;
  logic inc_q, inc_d, inc_en;

  logic [31:0] rdata_q, rdata_d;
  logic        rdata_en;

  logic wr_ctrl, wr_ptr, rd_any, rd_data;
  logic par_run;

  logic [WORDS-1:0][31:0] rom_words;
  logic                   latch_p, err_p;
  logic [PTR_W-1:0]       ptr;
  logic                   buf_valid;
  logic [31:0]            rd_word;

  // bus decode
  always_comb begin
    wr_ctrl = bus_cs && bus_we && (bus_addr == ADDR_W'(ADR_CTRL));
    wr_ptr  = bus_cs && bus_we && (bus_addr == ADDR_W'(ADR_PTR));
    rd_any  = bus_cs && !bus_we;
    rd_data = rd_any && (bus_addr == ADDR_W'(ADR_DATA));
  end

  assign par_run = por_q && !mode_q;

  otp_fuse_rom #(
    .NUM_BITS  (NUM_BITS),
    .WORDS     (WORDS),
    .FUSE_SEED (FUSE_SEED)
  ) u_rom (
    .rom_words (rom_words)
  );

  otp_strobe_seq #(
    .MIN_LOW (MIN_LOW)
  ) u_seq (
    .clk     (clk),
    .rst_n   (rst_n),
    .enable  (par_run),
    .stb     (stb_q),
    .latch_p (latch_p),
    .err_p   (err_p)
  );

  otp_word_buf #(
    .WORDS (WORDS),
    .PTR_W (PTR_W)
  ) u_buf (
    .clk       (clk),
    .rst_n     (rst_n),
    .rom_words (rom_words),
    .latch_p   (latch_p),
    .discard   (!por_q),
    .ptr_rst   (prst_q),
    .ptr_wr    (wr_ptr),
    .ptr_wdata (bus_wdata[PTR_W-1:0]),
    .advance   (rd_data && inc_q),
    .ptr       (ptr),
    .valid     (buf_valid),
    .rd_word   (rd_word)
  );

  // control next state
  always_comb begin
    ctrl_en = wr_ctrl;
    mode_d  = bus_wdata[CB_MODE];
    prst_d  = bus_wdata[CB_PRST];
    por_d   = bus_wdata[CB_POR];
    stb_d   = bus_wdata[CB_STB];
    err_en  = err_p;
    err_d   = 1'b1;
    inc_en  = wr_ptr;
    inc_d   = bus_wdata[PB_INC];
  end

  // read data mux
  always_comb begin
    rdata_en = rd_any;
    rdata_d  = '0;
    if (bus_addr == ADDR_W'(ADR_CTRL)) begin
      rdata_d[CB_MODE] = mode_q;
      rdata_d[CB_PRST] = prst_q;
      rdata_d[CB_POR]  = por_q;
      rdata_d[CB_STB]  = stb_q;
      rdata_d[CB_ERR]  = err_q;
    end else if (bus_addr == ADDR_W'(ADR_PTR)) begin
      rdata_d[PB_INC]      = inc_q;
      rdata_d[PTR_W-1:0]   = ptr;
    end else if (bus_addr == ADDR_W'(ADR_DATA)) begin
      rdata_d = par_run ? rd_word : '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= 1'b0;
      prst_q <= 1'b0;
      por_q  <= 1'b0;
      stb_q  <= 1'b0;
    end else if (ctrl_en) begin
      mode_q <= mode_d;
      prst_q <= prst_d;
      por_q  <= por_d;
      stb_q  <= stb_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      err_q <= 1'b0;
    end else if (err_en) begin
      err_q <= err_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      inc_q <= 1'b0;
    end else if (inc_en) begin
      inc_q <= inc_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata_q <= '0;
    end else if (rdata_en) begin
      rdata_q <= rdata_d;
    end
  end

  assign bus_rdata = rdata_q;

endmodule

// File: rtl/otp_par_rd_ctrl_chk.sv
module otp_par_rd_ctrl_chk #(
  parameter int WORDS = 3,
  parameter int PTR_W = 2
) (
  input logic             clk,
  input logic             rst_n,
  input logic             rd_data,
  input logic             por_q,
  input logic             mode_q,
  input logic             prst_q,
  input logic             inc_q,
  input logic             wr_ptr,
  input logic             err_q,
  input logic             latch_p,
  input logic             err_p,
  input logic             buf_valid,
  input logic [PTR_W-1:0] ptr,
  input logic [31:0]      bus_rdata
);

  logic [PTR_W-1:0] ptr_next;
  assign ptr_next = (int'(ptr) >= WORDS - 1) ? '0 : ptr + PTR_W'(1);

  // R4
  data_gated_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_data && !por_q) |=> (bus_rdata == 32'h0));

  // R11
  serial_gated_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_data && mode_q) |=> (bus_rdata == 32'h0));

  // R6
  err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err_q |=> err_q);

  // R6
  short_no_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err_p |=> (err_q && $stable(buf_valid)));

  // R5
  latch_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(latch_p && err_p));

  // R7
  auto_inc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_data && inc_q && !prst_q && !wr_ptr) |=> (ptr == $past(ptr_next)));

  // R7
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!inc_q && !prst_q && !wr_ptr) |=> $stable(ptr));

  // R8
  ptr_rst_chk: assert property (@(posedge clk) disable iff (!rst_n)
    prst_q |=> (ptr == '0));

  // R10
  por_discard_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !por_q |=> !buf_valid);

endmodule

bind otp_par_rd_ctrl otp_par_rd_ctrl_chk #(
  .WORDS (WORDS),
  .PTR_W (PTR_W)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .rd_data   (rd_data),
  .por_q     (por_q),
  .mode_q    (mode_q),
  .prst_q    (prst_q),
  .inc_q     (inc_q),
  .wr_ptr    (wr_ptr),
  .err_q     (err_q),
  .latch_p   (latch_p),
  .err_p     (err_p),
  .buf_valid (buf_valid),
  .ptr       (ptr),
  .bus_rdata (bus_rdata)
);

// File: tb/otp_par_rd_ctrl_bench.sv
module otp_par_rd_ctrl_bench;

  localparam int          CLK_PERIOD = 10;
  localparam int          NUM_BITS   = 97;
  localparam int          MIN_LOW    = 4;
  localparam logic [31:0] SEED       = 32'hA5C3_5A3C;

  // expected fuse words per R9: SEED ^ (i * 0x01010101), word 3 keeps bit 0 only
  localparam logic [31:0] W0 = 32'hA5C3_5A3C;
  localparam logic [31:0] W1 = 32'hA4C2_5B3D;
  localparam logic [31:0] W2 = 32'hA7C1_583E;
  localparam logic [31:0] W3 = 32'h0000_0001;

  localparam logic [1:0] OP_WR = 2'd0;
  localparam logic [1:0] OP_RD = 2'd1;
  localparam logic [1:0] OP_ID = 2'd2;

  typedef struct packed {
    logic [1:0]  op;
    logic [3:0]  addr;
    logic [31:0] data;
    logic [3:0]  req;
  } vec_t;

  localparam int NVEC = 23;
  localparam vec_t TBL [NVEC] = '{
    '{OP_WR, 4'h0, 32'h0000_2000, 4'd4},   // release POR, parallel
    '{OP_RD, 4'h4, 32'h0000_0000, 4'd4},   // R4: no strobe yet
    '{OP_WR, 4'h8, 32'h0000_0100, 4'd3},   // enable auto-inc
    '{OP_RD, 4'h8, 32'h0000_0100, 4'd3},   // R3 readback
    '{OP_WR, 4'h0, 32'h0000_2008, 4'd5},   // strobe high
    '{OP_WR, 4'h0, 32'h0000_2000, 4'd5},   // strobe low
    '{OP_ID, 4'h0, 32'd3,         4'd5},   // low phase = MIN_LOW exactly
    '{OP_WR, 4'h0, 32'h0000_2008, 4'd5},   // strobe high again
    '{OP_ID, 4'h0, 32'd2,         4'd5},
    '{OP_RD, 4'h0, 32'h0000_2008, 4'd2},   // R2 readback
    '{OP_RD, 4'h4, W0,            4'd5},   // R5 word 0
    '{OP_RD, 4'h4, W1,            4'd7},   // R7 advanced
    '{OP_RD, 4'h4, W2,            4'd9},   // R9 content
    '{OP_RD, 4'h4, W3,            4'd9},   // R9 tail masked
    '{OP_RD, 4'h4, W0,            4'd7},   // R7 wrap
    '{OP_RD, 4'h8, 32'h0000_0101, 4'd7},   // R7 pointer after wrap
    '{OP_WR, 4'h0, 32'h0000_6008, 4'd8},   // pointer reset bit
    '{OP_WR, 4'h0, 32'h0000_2008, 4'd8},
    '{OP_RD, 4'h8, 32'h0000_0100, 4'd8},   // R8 pointer zero
    '{OP_WR, 4'h8, 32'h0000_0002, 4'd3},   // inc off, pointer 2
    '{OP_RD, 4'h4, W2,            4'd7},
    '{OP_RD, 4'h4, W2,            4'd7},   // R7 hold
    '{OP_RD, 4'h8, 32'h0000_0002, 4'd3}    // R3 readback
  };

  logic        clk;
  logic        rst_n;
  logic        bus_cs;
  logic        bus_we;
  logic [3:0]  bus_addr;
  logic [31:0] bus_wdata;
  logic [31:0] bus_rdata;

  int total;
  int bad;
  bit done;

  otp_par_rd_ctrl #(
    .NUM_BITS  (NUM_BITS),
    .MIN_LOW   (MIN_LOW),
    .FUSE_SEED (SEED),
    .ADDR_W    (4)
  ) u_otp_par_rd_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_cs    (bus_cs),
    .bus_we    (bus_we),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  // all tasks start and end at a falling edge
  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    bus_cs = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_cs = 1'b0; bus_we = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    bus_cs = 1'b1; bus_we = 1'b0; bus_addr = a;
    @(negedge clk);
    bus_cs = 1'b0;
    d = bus_rdata;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  // strobe: high, low for low_len cycles, high, then settle
  task automatic strobe(input logic [31:0] base, input int low_len);
    wr(4'h0, base | 32'h8);
    wr(4'h0, base);
    idle(low_len - 1);
    wr(4'h0, base | 32'h8);
    idle(2);
  endtask

  initial begin
    logic [31:0] v;
    total = 0; bad = 0; done = 1'b0;
    bus_cs = 1'b0; bus_we = 1'b0; bus_addr = '0; bus_wdata = '0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    check("R1 rdata", bus_rdata, 32'h0);
    rd(4'h0, v); check("R1 ctrl", v, 32'h0);
    rd(4'h8, v); check("R1 ptr", v, 32'h0);
    rd(4'h4, v); check("R1 data", v, 32'h0);

    // table walk
    for (int i = 0; i < NVEC; i++) begin
      case (TBL[i].op)
        OP_WR: wr(TBL[i].addr, TBL[i].data);
        OP_ID: idle(int'(TBL[i].data));
        default: begin
          rd(TBL[i].addr, v);
          check($sformatf("R%0d vec %0d", TBL[i].req, i), v, TBL[i].data);
        end
      endcase
    end

    // R10: POR low discards, re-release reads zero
    wr(4'h0, 32'h0000_0000);
    wr(4'h0, 32'h0000_2000);
    wr(4'h8, 32'h0000_0000);
    rd(4'h4, v); check("R10 discard", v, 32'h0);

    // R6: low one cycle short of MIN_LOW
    strobe(32'h0000_2000, MIN_LOW - 1);
    rd(4'h4, v); check("R6 no load", v, 32'h0);
    rd(4'h0, v); check("R6 err set", v, 32'h8000_2008);
    wr(4'h0, 32'h0000_2000);   // bit 31 write ignored
    rd(4'h0, v); check("R6 err sticky", v, 32'h8000_2000);

    // R5: a longer low phase loads data, error stays
    strobe(32'h0000_2000, MIN_LOW + 3);
    rd(4'h4, v); check("R5 long low", v, W0);
    rd(4'h0, v); check("R6 err kept", v, 32'h8000_2008);

    // R11: serial mode gates reads and ignores the strobe
    rd(4'h4, v); check("R4 running", v, W0);
    wr(4'h0, 32'h0000_A000);
    rd(4'h4, v); check("R11 serial read", v, 32'h0);
    wr(4'h0, 32'h0000_0000);
    wr(4'h0, 32'h0000_A000);
    strobe(32'h0000_A000, MIN_LOW + 1);
    wr(4'h0, 32'h0000_2000);
    rd(4'h4, v); check("R11 strobe ignored", v, 32'h0);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule